// File: doc/BRIEF.md
# Real-Mode Segment Address Unit

This unit turns a 16-bit segment selector and a 16-bit offset into a 20-bit physical byte address. The selector is placed four bit positions up, so every segment begins on a 16-byte boundary. The zero-extended offset is then added to it. Every segment is 64 KiB long and may be read, written or executed, so no limit or rights check applies to the address itself.

Along with the address, the unit decides whether the access trips one of the wrap or table overrun faults of real address mode. It reports which fault vector applies and whether the saved return address must point back at the faulting instruction. The kind of access selects which rule is tested:

- data accesses of one or two bytes;
- instruction fetches of a given byte span;
- coprocessor memory operands of a given byte span;
- interrupt vector lookups checked against the interrupt table limit.

All results are registered. They appear one cycle after a request strobe, together with a one-cycle done pulse. Between requests they hold their values.

Top module: `rm_seg_addr_unit`

## Requirements
- R1: On each request the physical address equals selector × 16 plus the offset, taken modulo 2^20. A fault does not suppress this wrap (selector FFFFh with offset 0010h gives 00000h).
- R2: The upper address bits output (bits 23..20) is always zero.
- R3: Done is high in the cycle after a request and only then. Address and fault outputs change only in that cycle and hold their values otherwise.
- R4: Data access (kind code 0). A byte access (word flag 0) never faults. A word access (word flag 1) at offset FFFFh faults with vector 13 and with the restart flag set to 1.
- R5: Instruction fetch (kind code 1). The span is a byte count, and a span of 0 counts as 1. The fetch faults with vector 13 and restart flag 1 when offset + span − 1 exceeds FFFFh.
- R6: Coprocessor operand (kind code 2). It uses the same span rule as R5, but faults with vector 9 and restart flag 0.
- R7: Interrupt vector lookup (kind code 3). It faults with vector 8 and restart flag 1 when interrupt number × 4 + 3 exceeds the table limit. Offset, word flag and span have no effect on this kind.
- R8: The table limit and interrupt number have no effect on the data, fetch and coprocessor kinds. The word flag has no effect on the fetch and coprocessor kinds. When no fault is found, fault, vector and restart are all 0. If several conditions hold at once, the priority is table overrun, then coprocessor overrun, then segment overrun.
- R9: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; inputs are sampled when it is high |
| seg_sel | input | 16 | Segment selector |
| offset | input | 16 | Byte offset within the segment |
| is_word | input | 1 | Data access size: 0 = byte, 1 = word |
| acc_kind | input | 2 | 0 data, 1 fetch, 2 coprocessor, 3 vector lookup |
| span | input | 4 | Byte count for fetch and coprocessor kinds (0 counts as 1) |
| int_num | input | 8 | Interrupt number for a vector lookup |
| tbl_limit | input | 16 | Interrupt table limit in bytes |
| done | output | 1 | One-cycle result-valid pulse |
| phys_addr | output | 20 | Physical byte address |
| addr_hi | output | 4 | Address bits 23..20, always zero |
| fault | output | 1 | A fault was detected |
| fault_vec | output | 8 | Fault vector number (8, 9 or 13), 0 with no fault |
| restart | output | 1 | Return address points at the faulting instruction |

## Verification
Every result of this unit becomes visible after one register stage. The address, fault, vector, restart flag and done pulse are all due right after the clock edge that samples the request. The bench raises the request at a falling edge and waits for the next rising edge. It samples one time unit later, where every expected value must already be present. One cycle after that, with the strobe low, it checks that done has dropped and that the address and fault outputs still hold the previous result.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 16;
    localparam int SHIFT  = 4;
    localparam int PA_W   = SEL_W + SHIFT;
    localparam int HI_W   = 4;
    localparam int SPAN_W = 4;
    localparam int VEC_W  = 8;
    localparam int LIM_W  = 16;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_COPRO = 2'd2,
        KIND_VECT  = 2'd3
    } acc_kind_e;

    localparam logic [7:0] VEC_TBL   = 8'd8;
    localparam logic [7:0] VEC_COPRO = 8'd9;
    localparam logic [7:0] VEC_SEG   = 8'd13;

    typedef struct packed {
        logic       fault;
        logic [7:0] vec;
        logic       restart;
    } fault_t;

    // last byte offset reached by an access of n bytes (n == 0 counts as 1);
    // bit OFF_W set means the access ran past the segment end
    function automatic logic [OFF_W:0] last_byte(input logic [OFF_W-1:0] off,
                                                 input logic [SPAN_W-1:0] n);
        logic [SPAN_W-1:0] extra;
        extra = (n == '0) ? '0 : n - 1'b1;
        return {1'b0, off} + (OFF_W+1)'(extra);
    endfunction

endpackage

// File: rtl/rm_base_adder.sv
module rm_base_adder
    import rm_addr_pkg::*;
(
    input  logic [SEL_W-1:0] seg_sel,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off_ext;

    always_comb begin
        base    = {seg_sel, {SHIFT{1'b0}}};
        off_ext = PA_W'(offset);
        phys    = base + off_ext;
    end
endmodule

// File: rtl/rm_fault_check.sv
module rm_fault_check
    import rm_addr_pkg::*;
(
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_word,
    input  acc_kind_e         kind,
    input  logic [SPAN_W-1:0] span,
    input  logic [VEC_W-1:0]  int_num,
    input  logic [LIM_W-1:0]  tbl_limit,
    output fault_t            result
);
    localparam int ENT_W = VEC_W + 2;

    logic [OFF_W:0]  span_end;
    logic [ENT_W-1:0] entry_end;
    logic tbl_ov, cop_ov, seg_ov;

    always_comb begin
        span_end  = last_byte(offset, span);
        entry_end = {int_num, 2'b11};
        tbl_ov = (kind == KIND_VECT) && (LIM_W'(entry_end) > tbl_limit);
        cop_ov = (kind == KIND_COPRO) && span_end[OFF_W];
        seg_ov = ((kind == KIND_DATA) && is_word && (offset == '1)) ||
                 ((kind == KIND_FETCH) && span_end[OFF_W]);

        result = '0;
        if (tbl_ov) begin
            result.fault   = 1'b1;
            result.vec     = VEC_TBL;
            result.restart = 1'b1;
        end else if (cop_ov) begin
            result.fault   = 1'b1;
            result.vec     = VEC_COPRO;
            result.restart = 1'b0;
        end else if (seg_ov) begin
            result.fault   = 1'b1;
            result.vec     = VEC_SEG;
            result.restart = 1'b1;
        end
    end
endmodule

// File: rtl/rm_seg_addr_unit.sv
module rm_seg_addr_unit
    import rm_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [15:0]       seg_sel,
    input  logic [15:0]       offset,
    input  logic              is_word,
    input  logic [1:0]        acc_kind,
    input  logic [3:0]        span,
    input  logic [7:0]        int_num,
    input  logic [15:0]       tbl_limit,
    output logic              done,
    output logic [19:0]       phys_addr,
    output logic [3:0]        addr_hi,
    output logic              fault,
    output logic [7:0]        fault_vec,
    output logic              restart
);
    logic [PA_W-1:0] phys_c;
    fault_t          flt_c;
    fault_t          flt_q;

    rm_base_adder u_adder (
        .seg_sel (seg_sel),
        .offset  (offset),
        .phys    (phys_c)
    );

    rm_fault_check u_fault (
        .offset    (offset),
        .is_word   (is_word),
        .kind      (acc_kind_e'(acc_kind)),
        .span      (span),
        .int_num   (int_num),
        .tbl_limit (tbl_limit),
        .result    (flt_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            phys_addr <= '0;
            flt_q     <= '0;
        end else begin
            done <= req;
            if (req) begin
                phys_addr <= phys_c;
                flt_q     <= flt_c;
            end
        end
    end

    assign addr_hi   = '0;
    assign fault     = flt_q.fault;
    assign fault_vec = flt_q.vec;
    assign restart   = flt_q.restart;

    // R3
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> done);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !done);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(phys_addr) && $stable(fault) && $stable(fault_vec)));
    // R1
    phys_sum_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> (phys_addr == (({4'b0, $past(seg_sel)} << 4) + {4'b0, $past(offset)})));
    // R4
    byte_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (req && acc_kind == 2'd0 && !is_word) |=> !fault);
    // R6
    cop_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault_vec == 8'd9) |-> !restart);
    // R8
    clean_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |-> (fault_vec == 8'd0 && !restart));
endmodule

// File: tb/rm_seg_addr_unit_tb.sv
module rm_seg_addr_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [15:0] seg_sel, offset, tbl_limit;
    logic        is_word;
    logic [1:0]  acc_kind;
    logic [3:0]  span;
    logic [7:0]  int_num;
    logic        done, fault, restart;
    logic [19:0] phys_addr;
    logic [3:0]  addr_hi;
    logic [7:0]  fault_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rm_seg_addr_unit u_dut (
        .clk(clk), .rst(rst), .req(req), .seg_sel(seg_sel), .offset(offset),
        .is_word(is_word), .acc_kind(acc_kind), .span(span), .int_num(int_num),
        .tbl_limit(tbl_limit), .done(done), .phys_addr(phys_addr),
        .addr_hi(addr_hi), .fault(fault), .fault_vec(fault_vec), .restart(restart)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one request; checks all results one cycle later, then the hold cycle
    task automatic access(input string tag, input logic [15:0] s, input logic [15:0] o,
                          input logic w, input logic [1:0] k, input logic [3:0] n,
                          input logic [7:0] inum, input logic [15:0] lim,
                          input logic ef, input logic [7:0] ev, input logic er);
        logic [19:0] ea;
        ea = ({4'b0, s} << 4) + {4'b0, o};
        @(negedge clk);
        seg_sel = s; offset = o; is_word = w; acc_kind = k; span = n;
        int_num = inum; tbl_limit = lim; req = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        chk("R3", "done", done, 1);
        chk("R1", "phys", phys_addr, ea);
        chk("R2", "addr_hi", addr_hi, 0);
        chk(tag, "fault", fault, ef);
        chk(tag, "vec", fault_vec, ev);
        chk(tag, "restart", restart, er);
        @(negedge clk);
        seg_sel = ~s; offset = ~o;
        @(posedge clk); #1;
        chk("R3", "done drop", done, 0);
        chk("R3", "phys hold", phys_addr, ea);
        chk("R3", "fault hold", fault, ef);
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b0; seg_sel = '0; offset = '0; is_word = 0;
        acc_kind = 0; span = 0; int_num = 0; tbl_limit = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "done", done, 0);
        chk("R9", "phys", phys_addr, 0);
        chk("R9", "fault", fault, 0);
        chk("R9", "vec", fault_vec, 0);
        chk("R9", "restart", restart, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_address();
        access("R1", 16'h1234, 16'h5678, 0, 2'd0, 0, 0, 0, 0, 0, 0);
        access("R1", 16'hFFFF, 16'h0010, 0, 2'd0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_data();
        access("R4", 16'h0100, 16'hFFFF, 0, 2'd0, 0, 0, 0, 0, 0, 0);
        access("R4", 16'h0100, 16'hFFFE, 1, 2'd0, 0, 0, 0, 0, 0, 0);
        access("R4", 16'h0100, 16'hFFFF, 1, 2'd0, 0, 0, 0, 1, 8'd13, 1);
    endtask

    task automatic t_fetch();
        access("R5", 16'h2000, 16'hFFFD, 0, 2'd1, 4'd3, 0, 0, 0, 0, 0);
        access("R5", 16'h2000, 16'hFFFE, 0, 2'd1, 4'd3, 0, 0, 1, 8'd13, 1);
        access("R5", 16'h2000, 16'hFFFF, 1, 2'd1, 4'd0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_copro();
        access("R6", 16'h3000, 16'hFFF6, 0, 2'd2, 4'd10, 0, 0, 0, 0, 0);
        access("R6", 16'h3000, 16'hFFF7, 0, 2'd2, 4'd10, 0, 0, 1, 8'd9, 0);
    endtask

    task automatic t_vector();
        access("R7", 16'h0000, 16'h0080, 0, 2'd3, 0, 8'h20, 16'h0083, 0, 0, 0);
        access("R7", 16'h0000, 16'h0080, 0, 2'd3, 0, 8'h20, 16'h0082, 1, 8'd8, 1);
        access("R7", 16'h0000, 16'hFFFF, 1, 2'd3, 4'd15, 8'hFF, 16'hFFFF, 0, 0, 0);
        access("R7", 16'h0000, 16'hFFFF, 1, 2'd3, 4'd15, 8'h00, 16'h0002, 1, 8'd8, 1);
    endtask

    task automatic t_ignore();
        access("R8", 16'h4000, 16'h0010, 1, 2'd0, 0, 8'hFF, 16'h0000, 0, 0, 0);
        access("R8", 16'h4000, 16'h0010, 1, 2'd2, 4'd4, 8'hFF, 16'h0000, 0, 0, 0);
        access("R8", 16'h4000, 16'hFFFF, 1, 2'd1, 4'd1, 8'hFF, 16'h0000, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_address();
        t_data();
        t_fetch();
        t_copro();
        t_vector();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule